// File: doc/BRIEF.md
# Parallel-Port Mode Negotiation Host Sequencer

This block is the host end of the handshake that moves a parallel peripheral interface out of plain forward printing and into one of four advanced transfer modes. A single-cycle start pulse and a request byte begin the run. The block puts the byte on the data lines and drives the three host control lines (select-request, auto-feed and strobe, all active low) through a fixed order. While it does so, it watches four status lines from the peripheral: acknowledge, paper-empty, fault and online.

Each run ends with a one-cycle done pulse and a set of result flags. The flags say whether the peripheral answered as a compliant device, whether it accepts the requested mode, and whether it has reverse-channel data waiting. A request byte outside the four legal codes is refused at once, and no line moves. A peripheral that never answers is detected by a timeout counter, and the control lines then go back to their idle levels. The data transfer phases that follow a run belong to other logic.

Top module: `nego_host`

## Requirements
- R1: After reset the block drives sel_n_o=0, feed_n_o=1, strb_n_o=1 and pd_oe_o=0. It also holds done_o, is1284_o, accepted_o, rev_avail_o and bad_mode_o at 0.
- R2: Only four request codes are legal: 0x00 (nibble), 0x01 (byte), 0x10 (extended-capability) and 0x40 (enhanced address/data). For any other code, a start sampled at a clock edge raises done_o and bad_mode_o after that same edge. is1284_o, accepted_o and rev_avail_o stay 0, and no control or data line changes.
- R3: For a legal code, the edge that samples start drives pd_o to the code, sets pd_oe_o to 1 and sets sel_n_o to 0. The edge after that sets sel_n_o to 1 and feed_n_o to 0.
- R4: strb_n_o goes low only after the synchronized status shows ack_n_i=0, paper_i=1, fault_n_i=1 and online_i=1 together. While strb_n_o is low, sel_n_o=1, feed_n_o=0, pd_oe_o=1, and pd_o stays equal to the request code.
- R5: strb_n_o stays low for exactly STRB_CYC clock cycles. It returns high in the same cycle that feed_n_o returns high.
- R6: When the synchronized ack_n_i returns high after the strobe, the run ends with is1284_o=1, accepted_o equal to online_i and rev_avail_o equal to the inverse of fault_n_i. Both status values are taken at that point.
- R7: If the response of R4 has not arrived, done_o rises after edge TIMEOUT_CYC+1, counting from the edge that sampled start. At that point is1284_o=0, sel_n_o=0, feed_n_o=1 and pd_oe_o=0.
- R8: done_o is high for a single cycle. The result flags keep their values until the next accepted start.
- R9: Every status input passes through a two-stage synchronizer. A rise of ack_n_i in the closing phase shows up on done_o after the third rising clock edge that follows it.
- R10: When a run ends, pd_oe_o=0. sel_n_o stays 1 if the mode was accepted and returns to 0 if it was refused.
- R11: If ack_n_i does not return high within TIMEOUT_CYC cycles after the strobe ends, the run ends with all result flags at 0 and sel_n_o=0, feed_n_o=1.
- R12: A start pulse that arrives while a run is in progress is ignored. The run in progress ends with bad_mode_o=0 and with pd_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to begin a run |
| mode_i | input | 8 | Request code, sampled with start_i |
| ack_n_i | input | 1 | Peripheral acknowledge, active low (asynchronous) |
| paper_i | input | 1 | Peripheral paper-empty status (asynchronous) |
| fault_n_i | input | 1 | Peripheral fault, active low (asynchronous) |
| online_i | input | 1 | Peripheral online/select status (asynchronous) |
| pd_o | output | 8 | Data lines carrying the request code |
| pd_oe_o | output | 1 | Output enable for pd_o |
| sel_n_o | output | 1 | Host select-request line, active low |
| feed_n_o | output | 1 | Host auto-feed line, active low |
| strb_n_o | output | 1 | Host strobe line, active low |
| done_o | output | 1 | One-cycle end-of-run pulse |
| is1284_o | output | 1 | The peripheral answered as a compliant device |
| accepted_o | output | 1 | The requested mode was accepted |
| rev_avail_o | output | 1 | The peripheral has reverse-channel data waiting |
| bad_mode_o | output | 1 | The request code was illegal |

## Verification
Results from the host's own registered outputs are checked at fixed cycle offsets from the edge that samples start. The refusal of an illegal code is due right after that edge. The byte is due after that edge and the request one edge later. The timeout is due after edge TIMEOUT_CYC+1. Anything that reacts to the peripheral has two synchronizer stages plus one output register in its path. For that reason the bench raises acknowledge on a falling edge and checks that done_o is still low after the second following rising edge and high after the third. Every sample is taken on a falling edge, so each check lands halfway between the edge that produces the value and the next one. The strobe width is counted one falling edge at a time.

// File: rtl/nego_pkg.sv
package nego_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_REQ,
        ST_STRB,
        ST_CONF
    } nego_st_e;

    localparam logic [7:0] XB_NIBBLE    = 8'h00;
    localparam logic [7:0] XB_BYTE      = 8'h01;
    localparam logic [7:0] XB_FAST_FWD  = 8'h10;
    localparam logic [7:0] XB_ADDR_DATA = 8'h40;

    function automatic logic xb_legal(input logic [7:0] code);
        return (code == XB_NIBBLE) || (code == XB_BYTE) ||
               (code == XB_FAST_FWD) || (code == XB_ADDR_DATA);
    endfunction

endpackage

// File: rtl/nego_sync.sv
module nego_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stg
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= g_stg[g-1].r;
            end
        end
    end

    assign q_o = g_stg[STAGES-1].r;

endmodule

// File: rtl/nego_fsm.sv
module nego_fsm
    import nego_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int STRB_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] mode_i,
    input  logic       ack_n_s,
    input  logic       paper_s,
    input  logic       fault_n_s,
    input  logic       online_s,
    output logic [7:0] pd_o,
    output logic       pd_oe_o,
    output logic       sel_n_o,
    output logic       feed_n_o,
    output logic       strb_n_o,
    output logic       done_o,
    output logic       is1284_o,
    output logic       accepted_o,
    output logic       rev_avail_o,
    output logic       bad_mode_o
);

    localparam int MAXC  = (TIMEOUT_CYC > STRB_CYC) ? TIMEOUT_CYC : STRB_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] TO_LOAD = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] SB_LOAD = CNT_W'(STRB_CYC - 1);

    typedef struct packed {
        nego_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       pd;
        logic             oe;
        logic             sel;
        logic             feed;
        logic             strb;
        logic             done;
        logic             is1284;
        logic             acc;
        logic             rev;
        logic             bad;
    } nego_regs_t;

    localparam nego_regs_t RESET_VAL = '{
        st: ST_IDLE, cnt: '0, pd: '0, oe: 1'b0, sel: 1'b0, feed: 1'b1,
        strb: 1'b1, done: 1'b0, is1284: 1'b0, acc: 1'b0, rev: 1'b0, bad: 1'b0
    };

    nego_regs_t q, d;

    logic resp_ok;
    assign resp_ok = !ack_n_s && paper_s && fault_n_s && online_s;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.is1284 = 1'b0;
                    d.acc    = 1'b0;
                    d.rev    = 1'b0;
                    if (xb_legal(mode_i)) begin
                        d.st  = ST_DRIVE;
                        d.pd  = mode_i;
                        d.oe  = 1'b1;
                        d.sel = 1'b0;
                        d.bad = 1'b0;
                    end else begin
                        d.done = 1'b1;
                        d.bad  = 1'b1;
                    end
                end
            end
            ST_DRIVE: begin
                d.st   = ST_REQ;
                d.sel  = 1'b1;
                d.feed = 1'b0;
                d.cnt  = TO_LOAD;
            end
            ST_REQ: begin
                if (resp_ok) begin
                    d.st   = ST_STRB;
                    d.strb = 1'b0;
                    d.cnt  = SB_LOAD;
                end else if (q.cnt == '0) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.sel  = 1'b0;
                    d.feed = 1'b1;
                    d.oe   = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_STRB: begin
                if (q.cnt == '0) begin
                    d.st   = ST_CONF;
                    d.strb = 1'b1;
                    d.feed = 1'b1;
                    d.cnt  = TO_LOAD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CONF: begin
                if (ack_n_s) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.is1284 = 1'b1;
                    d.acc    = online_s;
                    d.rev    = !fault_n_s;
                    d.sel    = online_s;
                    d.oe     = 1'b0;
                end else if (q.cnt == '0) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.sel  = 1'b0;
                    d.oe   = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign pd_o        = q.pd;
    assign pd_oe_o     = q.oe;
    assign sel_n_o     = q.sel;
    assign feed_n_o    = q.feed;
    assign strb_n_o    = q.strb;
    assign done_o      = q.done;
    assign is1284_o    = q.is1284;
    assign accepted_o  = q.acc;
    assign rev_avail_o = q.rev;
    assign bad_mode_o  = q.bad;

    // Strobe-width watcher, used only by the assertions below.
    logic [CNT_W-1:0] low_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_cnt_q <= '0;
        else if (!q.strb) low_cnt_q <= (low_cnt_q == {CNT_W{1'b1}}) ? low_cnt_q : low_cnt_q + 1'b1;
        else              low_cnt_q <= '0;
    end

    a_r4_strobe_framing: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_n_o |-> (sel_n_o && !feed_n_o && pd_oe_o));

    a_r4_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_n_o && $past(!strb_n_o)) |-> $stable(pd_o));

    a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_n_o) |-> (low_cnt_q == CNT_W'(STRB_CYC)));

    a_r5_feed_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_n_o) |-> feed_n_o);

    a_r6_accept_needs_1284: assert property (@(posedge clk) disable iff (!rst_n)
        accepted_o |-> is1284_o);

    a_r2_bad_clean: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode_o |-> (!is1284_o && !accepted_o && !rev_avail_o));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !is1284_o && !bad_mode_o) |-> (!sel_n_o && feed_n_o && !pd_oe_o));

endmodule

// File: rtl/nego_host.sv
module nego_host #(
    parameter int TIMEOUT_CYC = 64,
    parameter int STRB_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] mode_i,
    input  logic       ack_n_i,
    input  logic       paper_i,
    input  logic       fault_n_i,
    input  logic       online_i,
    output logic [7:0] pd_o,
    output logic       pd_oe_o,
    output logic       sel_n_o,
    output logic       feed_n_o,
    output logic       strb_n_o,
    output logic       done_o,
    output logic       is1284_o,
    output logic       accepted_o,
    output logic       rev_avail_o,
    output logic       bad_mode_o
);

    localparam int NSTAT = 4;

    logic [NSTAT-1:0] stat_raw, stat_s;
    assign stat_raw = {ack_n_i, paper_i, fault_n_i, online_i};

    nego_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (stat_raw),
        .q_o   (stat_s)
    );

    nego_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC), .STRB_CYC(STRB_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .ack_n_s     (stat_s[3]),
        .paper_s     (stat_s[2]),
        .fault_n_s   (stat_s[1]),
        .online_s    (stat_s[0]),
        .pd_o        (pd_o),
        .pd_oe_o     (pd_oe_o),
        .sel_n_o     (sel_n_o),
        .feed_n_o    (feed_n_o),
        .strb_n_o    (strb_n_o),
        .done_o      (done_o),
        .is1284_o    (is1284_o),
        .accepted_o  (accepted_o),
        .rev_avail_o (rev_avail_o),
        .bad_mode_o  (bad_mode_o)
    );

endmodule

// File: tb/nego_host_tb.sv
`timescale 1ns/1ps
module nego_host_tb;

    localparam int TO = 64;
    localparam int SB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] mode_i = 8'h00;
    logic       ack_n_i = 1'b1, paper_i = 1'b0, fault_n_i = 1'b1, online_i = 1'b1;
    logic [7:0] pd_o;
    logic       pd_oe_o, sel_n_o, feed_n_o, strb_n_o;
    logic       done_o, is1284_o, accepted_o, rev_avail_o, bad_mode_o;

    int vecs = 0;
    int miss = 0;

    always #5 clk = ~clk;

    nego_host #(.TIMEOUT_CYC(TO), .STRB_CYC(SB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .ack_n_i(ack_n_i), .paper_i(paper_i), .fault_n_i(fault_n_i), .online_i(online_i),
        .pd_o(pd_o), .pd_oe_o(pd_oe_o), .sel_n_o(sel_n_o), .feed_n_o(feed_n_o),
        .strb_n_o(strb_n_o), .done_o(done_o), .is1284_o(is1284_o),
        .accepted_o(accepted_o), .rev_avail_o(rev_avail_o), .bad_mode_o(bad_mode_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic periph_idle();
        ack_n_i = 1'b1; paper_i = 1'b0; fault_n_i = 1'b1; online_i = 1'b1;
    endtask

    // Drive start on a falling edge; return on the falling edge after the sampling edge.
    task automatic pulse_start(input logic [7:0] code);
        @(negedge clk);
        start_i = 1'b1; mode_i = code;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        periph_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sel", sel_n_o, 1'b0);
        check("R1 feed", feed_n_o, 1'b1);
        check("R1 strb", strb_n_o, 1'b1);
        check("R1 oe", pd_oe_o, 1'b0);
        check("R1 flags", {done_o, is1284_o, accepted_o, rev_avail_o, bad_mode_o}, 5'b0);
    endtask

    task automatic t_bad_code(input logic [7:0] code);
        logic sel_before;
        sel_before = sel_n_o;
        pulse_start(code);
        check("R2 done", done_o, 1'b1);
        check("R2 bad", bad_mode_o, 1'b1);
        check("R2 flags", {is1284_o, accepted_o, rev_avail_o}, 3'b0);
        check("R2 lines", {sel_n_o, feed_n_o, strb_n_o, pd_oe_o}, {sel_before, 3'b110});
        @(negedge clk);
        check("R8 pulse", done_o, 1'b0);
    endtask

    task automatic run_nego(input logic [7:0] code, input logic acc, input logic rev,
                            input logic poke);
        int n;
        pulse_start(code);
        check("R3 byte", pd_o, code);
        check("R3 oe", pd_oe_o, 1'b1);
        check("R3 sel low", sel_n_o, 1'b0);
        @(negedge clk);
        check("R3 request", {sel_n_o, feed_n_o}, 2'b10);
        if (poke) begin
            start_i = 1'b1; mode_i = 8'h33;
            @(negedge clk);
            start_i = 1'b0;
            check("R12 no done", done_o, 1'b0);
        end
        repeat (5) @(negedge clk);
        check("R4 no early strobe", strb_n_o, 1'b1);
        ack_n_i = 1'b0; paper_i = 1'b1; fault_n_i = 1'b1; online_i = 1'b1;
        n = 0;
        while (strb_n_o && n < 20) begin
            @(negedge clk);
            n++;
        end
        check("R4 strobe seen", strb_n_o, 1'b0);
        check("R4 byte during strobe", pd_o, code);
        n = 0;
        while (!strb_n_o && n < 50) begin
            @(negedge clk);
            n++;
        end
        check("R5 strobe width", n, SB);
        check("R5 feed high", feed_n_o, 1'b1);
        paper_i = 1'b0; fault_n_i = !rev; online_i = acc;
        repeat (4) @(negedge clk);
        check("R6 not yet done", done_o, 1'b0);
        ack_n_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 done not early", done_o, 1'b0);
        @(negedge clk);
        check("R9 done on time", done_o, 1'b1);
        check("R6 is1284", is1284_o, 1'b1);
        check("R6 accepted", accepted_o, acc);
        check("R6 rev", rev_avail_o, rev);
        check("R10 sel", sel_n_o, acc);
        check("R10 oe", pd_oe_o, 1'b0);
        if (poke) check("R12 bad clear", bad_mode_o, 1'b0);
        if (poke) check("R12 byte kept", pd_o, code);
        @(negedge clk);
        check("R8 single pulse", done_o, 1'b0);
        check("R8 held", {is1284_o, accepted_o, rev_avail_o}, {1'b1, acc, rev});
        periph_idle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_timeout(input logic [7:0] code);
        @(negedge clk);
        start_i = 1'b1; mode_i = code;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (TO) @(posedge clk);
        @(negedge clk);
        check("R7 not early", done_o, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R7 done", done_o, 1'b1);
        check("R7 not 1284", is1284_o, 1'b0);
        check("R7 lines", {sel_n_o, feed_n_o, pd_oe_o}, 3'b010);
    endtask

    task automatic t_conf_timeout(input logic [7:0] code);
        int n;
        logic seen;
        pulse_start(code);
        repeat (3) @(negedge clk);
        ack_n_i = 1'b0; paper_i = 1'b1; fault_n_i = 1'b1; online_i = 1'b1;
        seen = 1'b0;
        n = 0;
        while (!seen && n < 4 * TO) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
            n++;
        end
        check("R11 done", seen, 1'b1);
        check("R11 flags", {is1284_o, accepted_o, rev_avail_o}, 3'b0);
        check("R11 lines", {sel_n_o, feed_n_o}, 2'b01);
        periph_idle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miss++;
        $display("FAIL watchdog R8: actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        t_reset();
        t_bad_code(8'h02);
        t_bad_code(8'hFF);
        run_nego(8'h00, 1'b1, 1'b0, 1'b0);
        run_nego(8'h01, 1'b0, 1'b1, 1'b0);
        t_bad_code(8'h20);
        run_nego(8'h10, 1'b1, 1'b1, 1'b0);
        run_nego(8'h40, 1'b1, 1'b0, 1'b1);
        t_timeout(8'h01);
        t_conf_timeout(8'h40);
        run_nego(8'h01, 1'b0, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule